// File: doc/BRIEF.md
# Masked SIMD Funnel Shift-Right Unit

This block is one stage of a vector datapath. It views a 512-bit register as packed lanes of 16, 32 or 64 bits. In each lane, the matching lane of the high source sits directly above the matching lane of the low source. The joined double-width value is shifted right logically by a count taken from an 8-bit immediate. The low lane-width bits of the shifted value become the lane result.

A write mask, one bit per lane, decides which lanes take the shift result. Lanes that are not selected either keep the old destination value (merge) or are cleared (zero). A broadcast flag makes every lane take lane 0 of the high source as its upper half. The active vector length can be 128, 256 or 512 bits, and every result bit at or above that length is cleared.

The result is held in a register. An output strobe marks each new result one clock after the request. The output has no back-pressure: the consumer must take every result in the cycle its strobe is high. The error flag and the data are valid together with that strobe.

Top module: `simd_funnel_shr`

## Requirements
- R1: Lane size is chosen by `lane_sel` (0 = 16-bit, 1 = 32-bit, 2 = 64-bit). Vector length is chosen by `vlen_sel` (0 = 128, 1 = 256, 2 = 512 bits). Lane j occupies bits [j*W +: W]. Its result is the low W bits of ({src_hi lane j, src_lo lane j} >> count), with the `src_hi` lane in the upper half.
- R2: The shift count is `imm` ANDed with W-1 (15, 31 or 63). Higher `imm` bits have no effect.
- R3: A masked count of zero returns the `src_lo` lane unchanged.
- R4: When `mask_en` is 0, every active lane takes the shift result. When `mask_en` is 1, lane j takes it only if bit j of `lane_mask` is 1.
- R5: In merge mode (`zero_mode` = 0), an unselected active lane keeps its `dest_old` value.
- R6: In zeroing mode (`zero_mode` = 1), an unselected active lane is cleared.
- R7: With `bcast` = 1 and 32- or 64-bit lanes, every lane uses bits [W-1:0] of `src_hi` as its upper half.
- R8: `bcast` has no effect on 16-bit lanes.
- R9: Every result bit at or above the selected vector length is zero, whatever the mask and mode.
- R10: Bits of `lane_mask` at or above the active lane count (128/W << vlen_sel) have no effect.
- R11: `out_valid` is `in_valid` delayed by one clock. `out_data` is loaded only when a request is accepted and holds its value otherwise.
- R12: While synchronous reset `rst` is high, `out_valid`, `out_err` and `out_data` are cleared.
- R13: A select encoding of 3 on `lane_sel` or `vlen_sel` gives an all-zero result, with `out_err` high in that result's strobe cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| src_lo | input | 512 | Low-half source lanes |
| src_hi | input | 512 | High-half source lanes |
| dest_old | input | 512 | Old destination for merge |
| lane_mask | input | 32 | Per-lane write mask |
| mask_en | input | 1 | Enables the write mask |
| zero_mode | input | 1 | 1 = zero unselected lanes, 0 = merge |
| imm | input | 8 | Shift count immediate |
| lane_sel | input | 2 | Lane size select |
| vlen_sel | input | 2 | Vector length select |
| bcast | input | 1 | Use high-source lane 0 in all lanes |
| out_valid | output | 1 | Result strobe |
| out_data | output | 512 | Registered result |
| out_err | output | 1 | Illegal select flag, with out_valid |

## Verification
The assertions assume that the select and data inputs are meaningful only in cycles where `in_valid` is high. They also assume that the consumer samples `out_data` whenever `out_valid` is high, since the output cannot stall. The bench therefore drives every input one half-cycle before the clock edge and changes inputs only between strobes. Some of its idle cycles keep junk on the data inputs, which lets it show that the held result does not move.

// File: rtl/fsh_pkg.sv
package fsh_pkg;
  localparam int VEC_W   = 512;
  localparam int MASK_W  = 32;
  localparam int IMM_W   = 8;
  localparam int BASE_VL = 128;

  typedef enum logic [1:0] {
    LS_16  = 2'd0,
    LS_32  = 2'd1,
    LS_64  = 2'd2,
    LS_BAD = 2'd3
  } lane_sz_e;

  typedef enum logic [1:0] {
    VL_128 = 2'd0,
    VL_256 = 2'd1,
    VL_512 = 2'd2,
    VL_BAD = 2'd3
  } vlen_e;
endpackage

// File: rtl/fsh_lane_shift.sv
module fsh_lane_shift #(
  parameter int W    = 32,
  parameter int SH_W = $clog2(W)
) (
  input  logic [W-1:0]    lo,
  input  logic [W-1:0]    hi,
  input  logic [SH_W-1:0] sh,
  output logic [W-1:0]    res
);
  logic [2*W-1:0] joined;
  logic [W-1:0]   unused_top;

  // upper half from the high source, then a logical shift right
  assign joined     = {hi, lo} >> sh;
  assign res        = joined[W-1:0];
  assign unused_top = joined[2*W-1:W];
endmodule

// File: rtl/fsh_width_path.sv
module fsh_width_path
  import fsh_pkg::*;
#(
  parameter int DW     = VEC_W,
  parameter int LANE_W = 32,
  parameter int NL     = DW / LANE_W,
  parameter int SH_W   = $clog2(LANE_W)
) (
  input  logic [DW-1:0]   src_lo,
  input  logic [DW-1:0]   src_hi,
  input  logic [DW-1:0]   dest_old,
  input  logic [NL-1:0]   mask,
  input  logic            mask_en,
  input  logic            zero_mode,
  input  logic [SH_W-1:0] sh,
  input  logic [1:0]      vlen_sel,
  input  logic            bcast,
  output logic [DW-1:0]   res
);
  localparam int BASE_N = BASE_VL / LANE_W;
  localparam int CNT_W  = 8;

  logic [CNT_W-1:0] act_cnt;
  assign act_cnt = CNT_W'(BASE_N) << vlen_sel;

  for (genvar j = 0; j < NL; j++) begin : g_lane
    logic [LANE_W-1:0] lo_l, hi_l, shr_l, old_l, out_l;
    logic              in_range, take;

    assign lo_l     = src_lo[j*LANE_W +: LANE_W];
    assign old_l    = dest_old[j*LANE_W +: LANE_W];
    assign hi_l     = bcast ? src_hi[LANE_W-1:0] : src_hi[j*LANE_W +: LANE_W];
    assign in_range = CNT_W'(j) < act_cnt;
    assign take     = !mask_en || mask[j];

    fsh_lane_shift #(.W(LANE_W)) u_shift (
      .lo (lo_l),
      .hi (hi_l),
      .sh (sh),
      .res(shr_l)
    );

    always_comb begin
      if (!in_range)      out_l = '0;
      else if (take)      out_l = shr_l;
      else if (zero_mode) out_l = '0;
      else                out_l = old_l;
    end

    assign res[j*LANE_W +: LANE_W] = out_l;
  end
endmodule

// File: rtl/simd_funnel_shr.sv
module simd_funnel_shr
  import fsh_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [VEC_W-1:0]  src_lo,
  input  logic [VEC_W-1:0]  src_hi,
  input  logic [VEC_W-1:0]  dest_old,
  input  logic [MASK_W-1:0] lane_mask,
  input  logic              mask_en,
  input  logic              zero_mode,
  input  logic [IMM_W-1:0]  imm,
  input  logic [1:0]        lane_sel,
  input  logic [1:0]        vlen_sel,
  input  logic              bcast,
  output logic              out_valid,
  output logic [VEC_W-1:0]  out_data,
  output logic              out_err
);
  localparam int N_SIZES = 3;

  logic [VEC_W-1:0] path_res [N_SIZES];
  logic [VEC_W-1:0] nxt_data;
  logic             legal;
  logic [1:0]       unused_imm;

  assign unused_imm = imm[IMM_W-1:IMM_W-2];

  for (genvar g = 0; g < N_SIZES; g++) begin : g_size
    localparam int LW  = 16 << g;
    localparam int NLG = VEC_W / LW;
    localparam int SHG = $clog2(LW);
    logic bc_g;

    // broadcast only applies to the wider lane sizes
    if (g == 0) begin : g_nobc
      assign bc_g = 1'b0;
    end else begin : g_bc
      assign bc_g = bcast;
    end

    fsh_width_path #(.DW(VEC_W), .LANE_W(LW)) u_path (
      .src_lo   (src_lo),
      .src_hi   (src_hi),
      .dest_old (dest_old),
      .mask     (lane_mask[NLG-1:0]),
      .mask_en  (mask_en),
      .zero_mode(zero_mode),
      .sh       (imm[SHG-1:0]),
      .vlen_sel (vlen_sel),
      .bcast    (bc_g),
      .res      (path_res[g])
    );
  end

  assign legal = (lane_sz_e'(lane_sel) != LS_BAD) && (vlen_e'(vlen_sel) != VL_BAD);

  always_comb begin
    nxt_data = '0;
    if (legal) begin
      case (lane_sz_e'(lane_sel))
        LS_16:   nxt_data = path_res[0];
        LS_32:   nxt_data = path_res[1];
        LS_64:   nxt_data = path_res[2];
        default: nxt_data = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      out_err   <= in_valid && !legal;
      if (in_valid) out_data <= nxt_data;
    end
  end
endmodule

// File: rtl/fsh_checker.sv
module fsh_checker
  import fsh_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [MASK_W-1:0] lane_mask,
  input logic              mask_en,
  input logic              zero_mode,
  input logic [1:0]        lane_sel,
  input logic [1:0]        vlen_sel,
  input logic              out_valid,
  input logic [VEC_W-1:0]  out_data,
  input logic              out_err
);
  logic in_legal;
  assign in_legal = (lane_sel != 2'd3) && (vlen_sel != 2'd3);

  assert_valid_rise_R11: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));
  assert_err_zero_R13: assert property (@(posedge clk) disable iff (rst)
    out_err |-> (out_valid && out_data == '0));
  assert_err_legal_R13: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_legal) |=> !out_err);
  assert_vl128_top_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && vlen_sel == 2'd0) |=> out_data[VEC_W-1:128] == '0);
  assert_vl256_top_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && vlen_sel == 2'd1) |=> out_data[VEC_W-1:256] == '0);
  assert_zero_all_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mask_en && zero_mode && lane_mask == '0) |=> out_data == '0);
endmodule

bind simd_funnel_shr fsh_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .lane_mask(lane_mask),
  .mask_en  (mask_en),
  .zero_mode(zero_mode),
  .lane_sel (lane_sel),
  .vlen_sel (vlen_sel),
  .out_valid(out_valid),
  .out_data (out_data),
  .out_err  (out_err)
);

// File: tb/simd_funnel_shr_tb.sv
module simd_funnel_shr_tb;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [511:0] src_lo, src_hi, dest_old;
  logic [31:0]  lane_mask;
  logic         mask_en, zero_mode, bcast;
  logic [7:0]   imm;
  logic [1:0]   lane_sel, vlen_sel;
  logic         out_valid, out_err;
  logic [511:0] out_data;

  int total = 0;
  int bad   = 0;
  logic [511:0] e_data;

  always #10 clk = ~clk;

  simd_funnel_shr u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_lo(src_lo), .src_hi(src_hi),
    .dest_old(dest_old), .lane_mask(lane_mask), .mask_en(mask_en),
    .zero_mode(zero_mode), .imm(imm), .lane_sel(lane_sel), .vlen_sel(vlen_sel),
    .bcast(bcast), .out_valid(out_valid), .out_data(out_data), .out_err(out_err)
  );

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  // behavioural reference built from the requirement text
  function automatic logic [511:0] ref_calc();
    int w, nact, sh;
    logic [63:0]  wm, lo, hi, r;
    logic [127:0] cat;
    logic [511:0] acc = '0;
    if (lane_sel == 2'd3 || vlen_sel == 2'd3) return '0;
    w    = 16 << lane_sel;
    nact = (128 << vlen_sel) / w;
    sh   = int'(imm) & (w - 1);
    wm   = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    for (int j = 0; j < 512 / w; j++) begin
      if (j >= nact) continue;
      lo = 64'(src_lo >> (j * w)) & wm;
      hi = (bcast && w != 16) ? (64'(src_hi) & wm) : (64'(src_hi >> (j * w)) & wm);
      if (!mask_en || lane_mask[j]) begin
        cat = (128'(hi) << w) | 128'(lo);
        r   = 64'(cat >> sh) & wm;
      end else if (zero_mode) begin
        r = '0;
      end else begin
        r = 64'(dest_old >> (j * w)) & wm;
      end
      acc = acc | (512'(r) << (j * w));
    end
    return acc;
  endfunction

  task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: inputs already set at a falling edge, compare at the next one
  task automatic step(input string tag);
    logic e_valid, e_err;
    e_valid = in_valid;
    e_err   = in_valid && (lane_sel == 2'd3 || vlen_sel == 2'd3);
    if (in_valid) e_data = ref_calc();
    @(negedge clk);
    chk({tag, " valid"}, 512'(out_valid), 512'(e_valid));
    chk({tag, " err"},   512'(out_err),   512'(e_err));
    chk({tag, " data"},  out_data,        e_data);
  endtask

  task automatic setup(input logic [1:0] ls, input logic [1:0] vl, input logic [7:0] im);
    in_valid = 1'b1; lane_sel = ls; vlen_sel = vl; imm = im;
    src_lo = rnd512(); src_hi = rnd512(); dest_old = rnd512();
    lane_mask = '1; mask_en = 1'b0; zero_mode = 1'b0; bcast = 1'b0;
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; src_lo = '0; src_hi = '0; dest_old = '0;
    lane_mask = '0; mask_en = 1'b0; zero_mode = 1'b0; bcast = 1'b0;
    imm = '0; lane_sel = '0; vlen_sel = '0; e_data = '0;
    repeat (3) @(negedge clk);
    chk("R12 reset valid", 512'(out_valid), '0);
    chk("R12 reset err",   512'(out_err),   '0);
    chk("R12 reset data",  out_data,        '0);
    rst = 1'b0;

    setup(2'd0, 2'd2, 8'd5);   step("R1 w16 vl512");
    setup(2'd1, 2'd1, 8'h27);  step("R2 w32 count masked");
    setup(2'd2, 2'd2, 8'hC0);  step("R2 w64 high bits ignored");
    setup(2'd2, 2'd0, 8'd0);   step("R3 count zero");
    chk("R3 lane0 equals src_lo", out_data[63:0], src_lo[63:0]);
    setup(2'd1, 2'd2, 8'd9);   mask_en = 1'b1; lane_mask = 32'h0000_A5C3; step("R4 R5 merge");
    setup(2'd0, 2'd2, 8'd3);   mask_en = 1'b1; zero_mode = 1'b1; lane_mask = 32'h1234_8001;
    step("R6 zeroing");
    setup(2'd1, 2'd2, 8'd17);  bcast = 1'b1; step("R7 bcast w32");
    setup(2'd2, 2'd1, 8'd40);  bcast = 1'b1; step("R7 bcast w64");
    setup(2'd0, 2'd2, 8'd7);   bcast = 1'b1; step("R8 bcast w16");
    setup(2'd0, 2'd0, 8'd2);   step("R9 vl128");
    chk("R9 upper bits", out_data[511:128], '0);
    setup(2'd1, 2'd0, 8'd4);   mask_en = 1'b1; lane_mask = 32'hFFFF_FFF0; step("R10 high mask bits");
    chk("R10 lanes 0..3 merged", out_data[127:0], dest_old[127:0]);
    setup(2'd3, 2'd2, 8'd1);   step("R13 bad lane_sel");
    setup(2'd1, 2'd3, 8'd1);   step("R13 bad vlen_sel");
    setup(2'd1, 2'd2, 8'd6);   step("R11 load");
    in_valid = 1'b0; src_lo = rnd512(); lane_sel = 2'd3; step("R11 idle hold");
    step("R11 idle hold 2");

    for (int n = 0; n < 300; n++) begin
      setup(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), 8'($urandom));
      in_valid  = ($urandom_range(0, 4) != 0);
      mask_en   = 1'($urandom); zero_mode = 1'($urandom); bcast = 1'($urandom);
      lane_mask = $urandom;
      step("R1 random");
    end

    setup(2'd0, 2'd2, 8'd1); step("R12 pre-reset");
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    e_data = '0;
    chk("R12 mid reset valid", 512'(out_valid), '0);
    chk("R12 mid reset data",  out_data,        '0);
    rst = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule